// File: doc/BRIEF.md
# Remote Terminal Buffer Mode Controller

This block decides, for every message a MIL-STD-1553 remote terminal handles, how that message's data is stored. At the start of a message it reads the four buffer-control bits of the addressed subaddress's control word, the global simplified mode-command switch, and whether the command is a mode code. From these it registers the storage scheme for the message: indexed single buffer, circular variant 1, circular variant 2, ping-pong, or simplified descriptor storage. The protocol engine, the circular pointer arithmetic and the interrupt logic are outside this block.

Ping-pong state is kept per subaddress. The host can suspend and resume ping-pong through the stop request bit. The block takes such a request only when the next message starts. It reports the result on a status bit that belongs at bit 8 of the control word, and it pulses a write strobe whenever that status changes. While ping-pong runs, the active half (A or B) flips after each message that ends without error. While ping-pong is suspended, the half stays where it was.

When the simplified switch is set, mode code commands keep their message data inside a fixed 4-word descriptor block. The block supplies the word addresses for that block. The data word is written only for mode codes 16 to 31.

Top module: `rt_bufmode_ctrl`

## Requirements
- R1: For a subaddress command, `buf_mode` one cycle after `msg_start` is chosen by priority. The encodings are ping-pong 3, circular variant 2 = 2, circular variant 1 = 1 and indexed 0. Ping-pong enable outranks circular variant 2 enable, which outranks circular variant 1 enable. When all three enables are 0, the mode is indexed.
- R2: For a mode code command with `mc_simple_en`=0, `buf_mode` is 3 when ping-pong enable is 1 and 0 otherwise. Circular modes 1 and 2 never appear for a mode code command.
- R3: For a mode code command with `mc_simple_en`=1, `buf_mode` is 4 whatever the control bits are. Such a message changes neither `pp_on` nor `pp_half` of any subaddress and raises no `ack_we`.
- R4: In simplified handling, `desc_we`=1 and the addresses are fixed offsets from `desc_base`: `info_addr` = `desc_base`+1, `ttag_addr` = `desc_base`+2, `data_addr` = `desc_base`+3. `data_we` is 1 only when mode code bit 4 is set (codes 16 to 31). Outside simplified handling, `desc_we`, `data_we` and all three addresses are 0.
- R5: At each message start that is not simplified, the addressed subaddress's ping-pong status becomes (ping-pong enable AND NOT stop request). `ack_we` pulses for one cycle, one cycle after `msg_start`, exactly when that status changed. `ack_word` carries the new status at bit 8 and zeros elsewhere. `pp_on` changes at no other time.
- R6: When a ping-pong message with status on sees `msg_done` with `msg_err`=0, the subaddress's active half toggles, visible on `pp_half` one cycle later (0 = A, 1 = B). A `msg_done` with `msg_err`=1 leaves the half unchanged.
- R7: While ping-pong status is off, `pp_half` for that subaddress keeps its last value across any number of messages.
- R8: After reset, `buf_mode`=0, `pp_on`=0, `pp_half`=0, `ack_we`=0 and `desc_we`=0, and every subaddress starts with status off and half A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_start | input | 1 | One-cycle pulse at the start of a message; the command fields are valid |
| sa | input | SA_W | Subaddress or control-slot index of the message |
| is_mode_cmd | input | 1 | Command is a mode code command |
| mode_code | input | 5 | Mode code value |
| ctl_stop | input | 1 | Control word: stop ping-pong request |
| ctl_pp_en | input | 1 | Control word: ping-pong enable |
| ctl_cir2_en | input | 1 | Control word: circular variant 2 enable |
| ctl_cir1_en | input | 1 | Control word: circular variant 1 enable |
| mc_simple_en | input | 1 | Global switch for simplified mode-command handling |
| desc_base | input | AW | Word address of the message's descriptor block |
| msg_done | input | 1 | One-cycle pulse at the end of a message |
| msg_err | input | 1 | The message that is ending had an error |
| buf_mode | output | 3 | Storage scheme of the current message |
| pp_half | output | 1 | Active ping-pong half of the current subaddress |
| pp_on | output | 1 | Ping-pong status of the current subaddress |
| ack_we | output | 1 | Strobe to write the status back into the control word |
| ack_word | output | 16 | Status write-back value, status at bit 8 |
| desc_we | output | 1 | Simplified descriptor storage in use |
| info_addr | output | AW | Address of the message information word |
| ttag_addr | output | AW | Address of the time-tag word |
| data_addr | output | AW | Address of the data word |
| data_we | output | 1 | Data word slot is written |

## Verification
A corrupted per-subaddress status bit appears on `pp_on` one cycle after the next message to that subaddress starts. It also shows as a missing or extra `ack_we` pulse. A half bit that toggled wrongly first shows on `pp_half` in the cycle after `msg_done`. It then shows again on every later message to that subaddress, so the bench tracks the state of every subaddress across long message sequences. Sequences mix errors, stop and resume requests, and simplified mode commands that must leave that state alone.

// File: rtl/rt_bufmode_ctrl.sv
module rt_bufmode_ctrl #(
  parameter int SA_W = 5,
  parameter int AW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msg_start,
  input  logic [SA_W-1:0] sa,
  input  logic            is_mode_cmd,
  input  logic [4:0]      mode_code,
  input  logic            ctl_stop,
  input  logic            ctl_pp_en,
  input  logic            ctl_cir2_en,
  input  logic            ctl_cir1_en,
  input  logic            mc_simple_en,
  input  logic [AW-1:0]   desc_base,
  input  logic            msg_done,
  input  logic            msg_err,
  output logic [2:0]      buf_mode,
  output logic            pp_half,
  output logic            pp_on,
  output logic            ack_we,
  output logic [15:0]     ack_word,
  output logic            desc_we,
  output logic [AW-1:0]   info_addr,
  output logic [AW-1:0]   ttag_addr,
  output logic [AW-1:0]   data_addr,
  output logic            data_we
);
  localparam int NUM_SA = 1 << SA_W;
  localparam logic [2:0] M_IDX = 3'd0, M_C1 = 3'd1, M_C2 = 3'd2, M_PP = 3'd3, M_SMC = 3'd4;
  localparam logic [AW-1:0] OFS_INFO = AW'(1), OFS_TTAG = AW'(2), OFS_DATA = AW'(3);

  logic [NUM_SA-1:0] on_q, half_q;
  logic [SA_W-1:0]   cur_sa;
  logic [2:0]        cur_mode, dec_mode;
  logic              cur_simple, cur_hi, ack_q;
  logic [AW-1:0]     cur_base;
  logic              simple, new_on;

  assign simple = is_mode_cmd & mc_simple_en;
  assign new_on = ctl_pp_en & ~ctl_stop;

  always_comb begin
    if (simple)           dec_mode = M_SMC;
    else if (ctl_pp_en)   dec_mode = M_PP;
    else if (is_mode_cmd) dec_mode = M_IDX;
    else if (ctl_cir2_en) dec_mode = M_C2;
    else if (ctl_cir1_en) dec_mode = M_C1;
    else                  dec_mode = M_IDX;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q       <= '0;
      half_q     <= '0;
      cur_sa     <= '0;
      cur_mode   <= M_IDX;
      cur_simple <= 1'b0;
      cur_hi     <= 1'b0;
      cur_base   <= '0;
      ack_q      <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (msg_start) begin
        cur_sa     <= sa;
        cur_mode   <= dec_mode;
        cur_simple <= simple;
        cur_hi     <= mode_code[4];
        cur_base   <= desc_base;
        if (!simple) begin
          on_q[sa] <= new_on;
          ack_q    <= (new_on != on_q[sa]);
        end
      end else if (msg_done && !msg_err && cur_mode == M_PP && on_q[cur_sa]) begin
        half_q[cur_sa] <= ~half_q[cur_sa];
      end
    end
  end

  assign buf_mode  = cur_mode;
  assign pp_half   = half_q[cur_sa];
  assign pp_on     = on_q[cur_sa];
  assign ack_we    = ack_q;
  assign ack_word  = {7'b0, pp_on, 8'b0};
  assign desc_we   = cur_simple;
  assign data_we   = cur_simple & cur_hi;
  assign info_addr = cur_simple ? cur_base + OFS_INFO : '0;
  assign ttag_addr = cur_simple ? cur_base + OFS_TTAG : '0;
  assign data_addr = cur_simple ? cur_base + OFS_DATA : '0;

  assert_pp_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start && !is_mode_cmd && ctl_pp_en |=> buf_mode == M_PP);
  assert_mc_no_circ_R2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start && is_mode_cmd |=> buf_mode != M_C1 && buf_mode != M_C2);
  assert_simple_keeps_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start && is_mode_cmd && mc_simple_en |=> buf_mode == M_SMC && $stable(on_q) && !ack_we);
  assert_data_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |-> desc_we);
  assert_status_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_start |=> $stable(pp_on));
  assert_ack_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |-> $past(msg_start));
  assert_err_holds_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_start && msg_done && msg_err |=> $stable(pp_half));
  assert_suspend_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_start && !pp_on |=> $stable(pp_half));
endmodule

// File: tb/rt_bufmode_ctrl_bench.sv
module rt_bufmode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SA_W = 3;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_start = 0, is_mode_cmd = 0, ctl_stop = 0, ctl_pp_en = 0, ctl_cir2_en = 0, ctl_cir1_en = 0;
  logic mc_simple_en = 0, msg_done = 0, msg_err = 0;
  logic [SA_W-1:0] sa = '0;
  logic [4:0] mode_code = '0;
  logic [AW-1:0] desc_base = '0;
  logic [2:0] buf_mode;
  logic pp_half, pp_on, ack_we, desc_we, data_we;
  logic [15:0] ack_word;
  logic [AW-1:0] info_addr, ttag_addr, data_addr;

  int checks = 0, fails = 0;
  logic on_m[8];
  logic half_m[8];

  always #(CLK_PERIOD/2) clk = ~clk;

  rt_bufmode_ctrl #(.SA_W(SA_W), .AW(AW)) u_rt_bufmode_ctrl (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .sa(sa), .is_mode_cmd(is_mode_cmd),
    .mode_code(mode_code), .ctl_stop(ctl_stop), .ctl_pp_en(ctl_pp_en), .ctl_cir2_en(ctl_cir2_en),
    .ctl_cir1_en(ctl_cir1_en), .mc_simple_en(mc_simple_en), .desc_base(desc_base),
    .msg_done(msg_done), .msg_err(msg_err), .buf_mode(buf_mode), .pp_half(pp_half), .pp_on(pp_on),
    .ack_we(ack_we), .ack_word(ack_word), .desc_we(desc_we), .info_addr(info_addr),
    .ttag_addr(ttag_addr), .data_addr(data_addr), .data_we(data_we));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // b = {stop, pp_en, cir2_en, cir1_en}
  task automatic run_msg(input int s, input logic [3:0] b, input logic mc, input logic [4:0] code,
                         input logic sm, input logic [15:0] base, input logic er);
    int em;
    logic simple, non, eack;
    string rq;
    simple = mc && sm;
    if (simple) em = 4;
    else if (b[2]) em = 3;
    else if (mc) em = 0;
    else if (b[1]) em = 2;
    else if (b[0]) em = 1;
    else em = 0;
    rq = simple ? "R3" : (mc ? "R2" : "R1");
    @(negedge clk);
    msg_start = 1; sa = SA_W'(s); ctl_stop = b[3]; ctl_pp_en = b[2]; ctl_cir2_en = b[1];
    ctl_cir1_en = b[0]; is_mode_cmd = mc; mode_code = code; mc_simple_en = sm; desc_base = base;
    @(negedge clk);
    msg_start = 0;
    eack = 0;
    if (!simple) begin
      non = b[2] && !b[3];
      eack = (non != on_m[s]);
      on_m[s] = non;
    end
    chk(rq, "buf_mode", buf_mode, em);
    chk(simple ? "R3" : "R5", "pp_on", pp_on, on_m[s]);
    chk(simple ? "R3" : "R5", "ack_we", ack_we, eack);
    if (eack) chk("R5", "ack_word", ack_word, on_m[s] ? 16'h0100 : 16'h0000);
    chk(on_m[s] ? "R6" : "R7", "pp_half at start", pp_half, half_m[s]);
    chk("R4", "desc_we", desc_we, simple);
    chk("R4", "info_addr", info_addr, simple ? int'(16'(base + 16'd1)) : 0);
    chk("R4", "ttag_addr", ttag_addr, simple ? int'(16'(base + 16'd2)) : 0);
    chk("R4", "data_addr", data_addr, simple ? int'(16'(base + 16'd3)) : 0);
    chk("R4", "data_we", data_we, simple && code >= 5'd16);
    msg_done = 1; msg_err = er;
    @(negedge clk);
    msg_done = 0; msg_err = 0;
    if (em == 3 && on_m[s] && !er) half_m[s] = !half_m[s];
    chk(er ? "R6" : (on_m[s] ? "R6" : "R7"), "pp_half after done", pp_half, half_m[s]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin on_m[i] = 0; half_m[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R8", "buf_mode", buf_mode, 0);
    chk("R8", "pp_on", pp_on, 0);
    chk("R8", "pp_half", pp_half, 0);
    chk("R8", "ack_we", ack_we, 0);
    chk("R8", "desc_we", desc_we, 0);
    rst_n = 1;
    // full sweep of control bits, command kinds and global switch
    for (int rep = 0; rep < 2; rep++)
      for (int sm = 0; sm < 2; sm++)
        for (int mc = 0; mc < 2; mc++)
          for (int b = 0; b < 16; b++)
            run_msg((b + mc + rep) % 8, 4'(b), mc[0], 5'(b * 3 + rep * 16), sm[0],
                    16'(b * 4 + 16'hFFF0 * rep), (b % 5) == 2);
    // every mode code in simplified handling, including address wrap
    for (int c = 0; c < 32; c++)
      run_msg(c % 8, 4'(c % 16), 1'b1, 5'(c), 1'b1, 16'(c * 4 + 16'hFFE0), 1'b0);
    // ping-pong run, errors, suspend, resume on one slot
    for (int k = 0; k < 6; k++) run_msg(5, 4'b0100, 1'b0, 5'd0, 1'b0, 16'h0, k == 3);     // R6
    for (int k = 0; k < 4; k++) run_msg(5, 4'b1100, 1'b0, 5'd0, 1'b0, 16'h0, 1'b0);       // R7
    run_msg(5, 4'b0101, 1'b1, 5'd20, 1'b1, 16'h0040, 1'b0);                              // R3
    for (int k = 0; k < 3; k++) run_msg(5, 4'b0110, 1'b0, 5'd0, 1'b0, 16'h0, 1'b0);      // R5
    for (int k = 0; k < 3; k++) run_msg(6, 4'b0100, 1'b1, 5'd9, 1'b0, 16'h0, k == 1);     // R2
    run_msg(6, 4'b1100, 1'b1, 5'd9, 1'b0, 16'h0, 1'b0);
    run_msg(6, 4'b1100, 1'b1, 5'd9, 1'b0, 16'h0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule